// File: doc/BRIEF.md
# CAN Frame Field Sequencer

This block walks a transmitter through every field of one CAN data frame or remote frame. It produces one unstuffed bit at a time and a tag that names the field that bit belongs to. A frame starts when `start` is pulsed while the block is idle. At that moment the block latches the frame description: identifier, format, remote flag, length code, payload and a precomputed 15-bit CRC. From then on, each `bit_tick` pulse retires the bit on show and moves to the next one. A downstream bit stuffer and bit-timing stage consume `tx_bit` and `field`, and they generate `bit_tick` once per nominal bit. This block does not handle stuffing, arbitration loss or bit timing.

The controller has sixteen states, and each state is also the field tag on `field`. Transitions take place only on a tick that retires the last bit of the current state:

- IDLE→SOF happens on `start`.
- SOF→ID_A.
- ID_A→SRR in extended format; ID_A→RTR in standard format.
- SRR→IDE.
- IDE→ID_B in extended format; IDE→R0 in standard format.
- ID_B→RTR.
- RTR→R1 in extended format; RTR→IDE in standard format.
- R1→R0.
- R0→DLC.
- DLC→DATA when the data byte count is non-zero; DLC→CRC when it is zero.
- DATA→CRC.
- CRC→CRC_DEL→ACK_SLOT→ACK_DEL→EOF.
- EOF→IDLE. This transition raises `done` for one cycle.

A bit counter gives the position of the current bit inside the current field. A length unit gives the last position for each field.

Top module: `can_field_seq`

## Requirements
- R1: After reset, and whenever no frame is in progress, `busy`=0, `field`=0 (IDLE), `tx_bit`=1 and `done`=0.
- R2: A `start` pulse seen while idle latches all frame inputs. In the next cycle `busy`=1 and `field`=1 (SOF). A `start` pulse during a frame is ignored and changes neither that frame's output nor its input values.
- R3: While busy, `field` and `tx_bit` change only in the cycle after a `bit_tick`. Each tick retires exactly one bit.
- R4: The field tags are IDLE=0, SOF=1, ID_A=2, SRR=3, IDE=4, ID_B=5, RTR=6, R1=7, R0=8, DLC=9, DATA=10, CRC=11, CRC_DEL=12, ACK_SLOT=13, ACK_DEL=14, EOF=15. A standard frame has the fields SOF(1), ID_A(11), RTR(1), IDE(1), R0(1), DLC(4), DATA, CRC(15), CRC_DEL, ACK_SLOT, ACK_DEL and EOF(7), in that order.
- R5: An extended frame (`ext_fmt`=1) has the fields SOF, ID_A(11), SRR, IDE, ID_B(18), RTR, R1, R0, DLC(4), DATA, CRC(15), CRC_DEL, ACK_SLOT, ACK_DEL and EOF(7), in that order.
- R6: Identifier bits are sent MSB first. The standard ID_A field carries `ident[10:0]`. The extended ID_A field carries `ident[28:18]` and the ID_B field carries `ident[17:0]`.
- R7: SOF=0, SRR=1, R1=0 and R0=0. IDE equals `ext_fmt`. RTR equals `remote`.
- R8: The DLC field sends the 4-bit `dlc` exactly as given, MSB first, including values above 8.
- R9: DATA has 8×N bits, where N = min(`dlc`, 8) for a data frame and N = 0 for a remote frame. Bits are taken from `payload[63]` downward, so byte 0 occupies `payload[63:56]`.
- R10: The CRC field sends `crc_in[14:0]` MSB first. The value used is the one latched at start. CRC_DEL follows as a 1.
- R11: ACK_SLOT, ACK_DEL and all 7 EOF bits are 1.
- R12: A frame retires exactly 44+8N ticks in standard format and 64+8N in extended format. `done` is 1 for exactly the one cycle after the tick that retires the last EOF bit. In that same cycle `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a frame (honoured only while idle) |
| bit_tick | input | 1 | Retire the current bit |
| ext_fmt | input | 1 | 1 = 29-bit identifier, 0 = 11-bit |
| remote | input | 1 | 1 = remote frame |
| ident | input | 29 | Identifier (standard uses bits 10:0) |
| dlc | input | 4 | Data length code |
| payload | input | 64 | Data bytes, byte 0 in bits 63:56 |
| crc_in | input | 15 | Precomputed CRC sequence |
| busy | output | 1 | Frame in progress |
| tx_bit | output | 1 | Current unstuffed bit |
| field | output | 4 | Tag of the field of the current bit |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions check on every cycle the properties that do not depend on the frame contents:

- the recessive idle output;
- the fixed values of SOF, SRR, R0/R1 and the trailing delimiters, ACK and EOF;
- holding the current bit when no tick arrives;
- entering SOF after a start pulse;
- leaving SOF for ID_A;
- the single-cycle `done` that follows EOF.

Only the bench scenarios can show the rest. These are the exact field order for each format, the identifier, DLC, payload and CRC bit values, the clamping of data length, the empty data field of remote frames and the total tick count. The bench also shows that a start pulse arriving mid-frame with different inputs leaves the frame unchanged.

// File: rtl/can_fseq_pkg.sv
package can_fseq_pkg;
    localparam int ID_W      = 29;
    localparam int STD_ID_W  = 11;
    localparam int EXT_LO_W  = ID_W - STD_ID_W;
    localparam int DLC_W     = 4;
    localparam int MAX_BYTES = 8;
    localparam int DATA_W    = MAX_BYTES * 8;
    localparam int CRC_W     = 15;
    localparam int EOF_W     = 7;
    localparam int NB_W      = $clog2(MAX_BYTES + 1);
    localparam int CNT_W     = $clog2(DATA_W) + 1;

    typedef enum logic [3:0] {
        F_IDLE     = 4'd0,
        F_SOF      = 4'd1,
        F_ID_A     = 4'd2,
        F_SRR      = 4'd3,
        F_IDE      = 4'd4,
        F_ID_B     = 4'd5,
        F_RTR      = 4'd6,
        F_R1       = 4'd7,
        F_R0       = 4'd8,
        F_DLC      = 4'd9,
        F_DATA     = 4'd10,
        F_CRC      = 4'd11,
        F_CRC_DEL  = 4'd12,
        F_ACK_SLOT = 4'd13,
        F_ACK_DEL  = 4'd14,
        F_EOF      = 4'd15
    } fld_e;
endpackage

// File: rtl/can_field_len.sv
module can_field_len
    import can_fseq_pkg::*;
(
    input  fld_e             fld,
    input  logic [NB_W-1:0]  nbytes,
    output logic [CNT_W-1:0] last_idx
);
    logic [CNT_W-1:0] data_bits;

    always_comb begin
        data_bits = CNT_W'(nbytes) << 3;
        unique case (fld)
            F_ID_A:  last_idx = CNT_W'(STD_ID_W - 1);
            F_ID_B:  last_idx = CNT_W'(EXT_LO_W - 1);
            F_DLC:   last_idx = CNT_W'(DLC_W - 1);
            F_DATA:  last_idx = data_bits - 1'b1;
            F_CRC:   last_idx = CNT_W'(CRC_W - 1);
            F_EOF:   last_idx = CNT_W'(EOF_W - 1);
            default: last_idx = '0;
        endcase
    end
endmodule

// File: rtl/can_field_bit.sv
module can_field_bit
    import can_fseq_pkg::*;
(
    input  fld_e              fld,
    input  logic [CNT_W-1:0]  idx,
    input  logic              ext,
    input  logic              rtr,
    input  logic [ID_W-1:0]   ident,
    input  logic [DLC_W-1:0]  dlc,
    input  logic [DATA_W-1:0] payload,
    input  logic [CRC_W-1:0]  crc,
    output logic              bit_val
);
    logic [STD_ID_W-1:0] hi_sh;
    logic [EXT_LO_W-1:0] lo_sh;
    logic [DLC_W-1:0]    dlc_sh;
    logic [DATA_W-1:0]   dat_sh;
    logic [CRC_W-1:0]    crc_sh;

    always_comb begin
        hi_sh  = (ext ? ident[ID_W-1 -: STD_ID_W] : ident[STD_ID_W-1:0]) << idx;
        lo_sh  = ident[EXT_LO_W-1:0] << idx;
        dlc_sh = dlc << idx;
        dat_sh = payload << idx;
        crc_sh = crc << idx;
        unique case (fld)
            F_SOF, F_R1, F_R0: bit_val = 1'b0;
            F_ID_A:            bit_val = hi_sh[STD_ID_W-1];
            F_ID_B:            bit_val = lo_sh[EXT_LO_W-1];
            F_IDE:             bit_val = ext;
            F_RTR:             bit_val = rtr;
            F_DLC:             bit_val = dlc_sh[DLC_W-1];
            F_DATA:            bit_val = dat_sh[DATA_W-1];
            F_CRC:             bit_val = crc_sh[CRC_W-1];
            default:           bit_val = 1'b1;
        endcase
    end
endmodule

// File: rtl/can_field_seq.sv
module can_field_seq
    import can_fseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bit_tick,
    input  logic              ext_fmt,
    input  logic              remote,
    input  logic [ID_W-1:0]   ident,
    input  logic [DLC_W-1:0]  dlc,
    input  logic [DATA_W-1:0] payload,
    input  logic [CRC_W-1:0]  crc_in,
    output logic              busy,
    output logic              tx_bit,
    output logic [3:0]        field,
    output logic              done
);
    fld_e              fld_q, fld_d, succ;
    logic [CNT_W-1:0]  idx_q, idx_d, last_idx;
    logic              done_q, done_d, capture;
    logic              ext_q, rtr_q;
    logic [ID_W-1:0]   id_q;
    logic [DLC_W-1:0]  dlc_q;
    logic [DATA_W-1:0] pay_q;
    logic [CRC_W-1:0]  crc_q;
    logic [NB_W-1:0]   nby_q, nby_in;
    logic              bit_val;

    // Data byte count: zero for remote frames, clamped to MAX_BYTES otherwise
    always_comb begin
        if (remote)
            nby_in = '0;
        else if (dlc > DLC_W'(MAX_BYTES))
            nby_in = NB_W'(MAX_BYTES);
        else
            nby_in = NB_W'(dlc);
    end

    can_field_len u_len (
        .fld      (fld_q),
        .nbytes   (nby_q),
        .last_idx (last_idx)
    );

    can_field_bit u_bit (
        .fld     (fld_q),
        .idx     (idx_q),
        .ext     (ext_q),
        .rtr     (rtr_q),
        .ident   (id_q),
        .dlc     (dlc_q),
        .payload (pay_q),
        .crc     (crc_q),
        .bit_val (bit_val)
    );

    // Successor field once the current one has been fully retired
    always_comb begin
        unique case (fld_q)
            F_IDLE:     succ = F_SOF;
            F_SOF:      succ = F_ID_A;
            F_ID_A:     succ = ext_q ? F_SRR : F_RTR;
            F_SRR:      succ = F_IDE;
            F_IDE:      succ = ext_q ? F_ID_B : F_R0;
            F_ID_B:     succ = F_RTR;
            F_RTR:      succ = ext_q ? F_R1 : F_IDE;
            F_R1:       succ = F_R0;
            F_R0:       succ = F_DLC;
            F_DLC:      succ = (nby_q == '0) ? F_CRC : F_DATA;
            F_DATA:     succ = F_CRC;
            F_CRC:      succ = F_CRC_DEL;
            F_CRC_DEL:  succ = F_ACK_SLOT;
            F_ACK_SLOT: succ = F_ACK_DEL;
            F_ACK_DEL:  succ = F_EOF;
            F_EOF:      succ = F_IDLE;
        endcase
    end

    always_comb begin
        fld_d   = fld_q;
        idx_d   = idx_q;
        done_d  = 1'b0;
        capture = 1'b0;
        unique case (fld_q)
            F_IDLE: begin
                if (start) begin
                    fld_d   = F_SOF;
                    idx_d   = '0;
                    capture = 1'b1;
                end
            end
            default: begin
                if (bit_tick) begin
                    if (idx_q == last_idx) begin
                        fld_d  = succ;
                        idx_d  = '0;
                        done_d = (fld_q == F_EOF);
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q  <= F_IDLE;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            fld_q  <= fld_d;
            idx_q  <= idx_d;
            done_q <= done_d;
        end
    end

    // Frame description captured at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
            rtr_q <= 1'b0;
            id_q  <= '0;
            dlc_q <= '0;
            pay_q <= '0;
            crc_q <= '0;
            nby_q <= '0;
        end else if (capture) begin
            ext_q <= ext_fmt;
            rtr_q <= remote;
            id_q  <= ident;
            dlc_q <= dlc;
            pay_q <= payload;
            crc_q <= crc_in;
            nby_q <= nby_in;
        end
    end

    // Outputs
    always_comb begin
        busy   = (fld_q != F_IDLE);
        field  = fld_q;
        tx_bit = bit_val;
        done   = done_q;
    end
endmodule

// File: rtl/can_field_seq_chk.sv
module can_field_seq_chk
    import can_fseq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       bit_tick,
    input logic       busy,
    input logic       tx_bit,
    input logic [3:0] field,
    input logic       done
);
    p_idle_recessive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_bit && field == F_IDLE));

    p_start_to_sof_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (field == F_SOF));

    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> ($stable(field) && $stable(tx_bit)));

    p_sof_then_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (field == F_SOF && bit_tick) |=> (field == F_ID_A));

    p_sof_dominant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (field == F_SOF) |-> !tx_bit);

    p_reserved_dominant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (field == F_R0 || field == F_R1) |-> !tx_bit);

    p_srr_recessive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (field == F_SRR) |-> tx_bit);

    p_crc_delim_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (field == F_CRC_DEL) |-> tx_bit);

    p_tail_recessive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (field == F_ACK_SLOT || field == F_ACK_DEL || field == F_EOF) |-> tx_bit);

    p_done_after_eof_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(field == F_EOF && bit_tick)));

    p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind can_field_seq can_field_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bit_tick (bit_tick),
    .busy     (busy),
    .tx_bit   (tx_bit),
    .field    (field),
    .done     (done)
);

// File: tb/can_field_seq_test.sv
`timescale 1ns/1ps
module can_field_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        bit_tick = 1'b0;
    logic        ext_fmt = 1'b0;
    logic        remote = 1'b0;
    logic [28:0] ident = '0;
    logic [3:0]  dlc = '0;
    logic [63:0] payload = '0;
    logic [14:0] crc_in = '0;
    logic        busy, tx_bit, done;
    logic [3:0]  field;

    always #2.5 clk = ~clk;

    can_field_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_tick(bit_tick),
        .ext_fmt(ext_fmt), .remote(remote), .ident(ident), .dlc(dlc),
        .payload(payload), .crc_in(crc_in),
        .busy(busy), .tx_bit(tx_bit), .field(field), .done(done)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    int q[$];
    bit busy_m = 0;
    bit done_m = 0;
    int dut_ticks = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string req_of(input int tag);
        case (tag)
            0:                 return "R1 idle";
            2, 5:              return "R6 identifier";
            9:                 return "R8 dlc";
            10:                return "R9 data";
            11, 12:            return "R10 crc";
            13, 14, 15:        return "R11 tail";
            default:           return "R7 fixed bits / R4 R5 order";
        endcase
    endfunction

    task automatic push(input int tag, input bit b);
        q.push_back(tag * 2 + int'(b));
    endtask

    // Reference frame built from the requirements
    task automatic build();
        int n;
        n = remote ? 0 : (dlc > 8 ? 8 : int'(dlc));
        q.delete();
        push(1, 1'b0);
        if (ext_fmt) begin
            for (int i = 28; i >= 18; i--) push(2, ident[i]);
            push(3, 1'b1);
            push(4, 1'b1);
            for (int i = 17; i >= 0; i--) push(5, ident[i]);
            push(6, remote);
            push(7, 1'b0);
        end else begin
            for (int i = 10; i >= 0; i--) push(2, ident[i]);
            push(6, remote);
            push(4, 1'b0);
        end
        push(8, 1'b0);
        for (int i = 3; i >= 0; i--) push(9, dlc[i]);
        for (int i = 0; i < 8 * n; i++) push(10, payload[63 - i]);
        for (int i = 14; i >= 0; i--) push(11, crc_in[i]);
        push(12, 1'b1);
        push(13, 1'b1);
        push(14, 1'b1);
        for (int i = 0; i < 7; i++) push(15, 1'b1);
    endtask

    // Runs at a negedge: compare, drive, cross the posedge, update model
    task automatic cyc(input bit st, input bit tk);
        int ef, eb;
        ef = busy_m ? (q[0] >> 1) : 0;
        eb = busy_m ? (q[0] & 1) : 1;
        chk(busy === busy_m, "R2 busy", int'(busy), int'(busy_m));
        chk(field === 4'(ef), req_of(ef), int'(field), ef);
        chk(tx_bit === eb[0], req_of(ef), int'(tx_bit), eb);
        chk(done === done_m, "R12 done", int'(done), int'(done_m));
        start = st;
        bit_tick = tk;
        if (busy && tk) dut_ticks++;
        @(posedge clk);
        done_m = 0;
        if (!busy_m) begin
            if (st) begin
                build();
                busy_m = 1;
            end
        end else if (tk) begin
            void'(q.pop_front());
            if (q.size() == 0) begin
                busy_m = 0;
                done_m = 1;
            end
        end
        @(negedge clk);
    endtask

    task automatic run_frame(input bit e, input bit r, input logic [28:0] id,
                             input logic [3:0] l, input logic [63:0] p,
                             input logic [14:0] c, input int mode);
        int n, exp_len, k;
        logic [3:0] pf;
        logic pb;
        n = r ? 0 : (l > 8 ? 8 : int'(l));
        exp_len = (e ? 64 : 44) + 8 * n;
        ext_fmt = e; remote = r; ident = id; dlc = l; payload = p; crc_in = c;
        dut_ticks = 0;
        cyc(1'b1, 1'b0);
        chk(busy && field == 4'd1, "R2 start->SOF", int'(field), 1);
        k = 0;
        while (busy_m) begin
            bit tk;
            case (mode)
                0: tk = 1'b1;
                1: tk = (k % 3 == 2);
                default: tk = 1'($urandom_range(0, 1));
            endcase
            // R2: stray start mid-frame with different inputs must be ignored
            if (k == 20) begin
                ext_fmt = ~e; remote = ~r; ident = ~id; dlc = ~l;
                payload = ~p; crc_in = ~c;
                cyc(1'b1, 1'b0);
            end else if (!tk) begin
                pf = field; pb = tx_bit;
                cyc(1'b0, 1'b0);
                chk(field == pf && tx_bit == pb, "R3 hold without tick",
                    int'({field, tx_bit}), int'({pf, pb}));
            end else begin
                cyc(1'b0, 1'b1);
            end
            k++;
            if (k > 5000) break;
        end
        chk(done === 1'b1 && busy === 1'b0, "R12 done pulse", int'(done), 1);
        chk(dut_ticks == exp_len, "R12 frame length", dut_ticks, exp_len);
        cyc(1'b0, 1'b0);
        chk(done === 1'b0, "R12 done one cycle", int'(done), 0);
        cyc(1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && field === 4'd0 && tx_bit === 1'b1 && done === 1'b0,
            "R1 reset state", int'({busy, field, tx_bit, done}), 'h02);
        rst_n = 1'b1;
        @(negedge clk);
        cyc(1'b0, 1'b1);
        run_frame(1'b0, 1'b0, 29'h0000_0555, 4'd2, 64'hA5C3_0000_0000_0000, 15'h5A3C, 0); // R4
        run_frame(1'b0, 1'b1, 29'h0000_07F0, 4'd5, 64'hFFFF_FFFF_FFFF_FFFF, 15'h1234, 1); // R9 remote
        run_frame(1'b1, 1'b0, 29'h1234_5678, 4'd8, 64'h0123_4567_89AB_CDEF, 15'h7001, 2); // R5 R6
        run_frame(1'b1, 1'b0, 29'h1FFF_0001, 4'd15, 64'h8000_0000_0000_0001, 15'h4321, 0); // R8 clamp
        run_frame(1'b0, 1'b0, 29'h1FFF_F800, 4'd0, 64'hDEAD_BEEF_0000_0000, 15'h0F0F, 1); // R9 empty
        run_frame(1'b1, 1'b1, 29'h0AAA_AAAA, 4'd3, 64'h5555_5555_5555_5555, 15'h7FFF, 2); // R10
        run_frame(1'b0, 1'b0, 29'h0000_0001, 4'd9, 64'hC001_D00D_F00D_BA5E, 15'h0001, 2); // R8 R9
        for (int i = 0; i < 3; i++)
            run_frame(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 29'($urandom),
                      4'($urandom), {$urandom, $urandom}, 15'($urandom), 2);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule